// File: doc/BRIEF.md
# Byte-Interleaved Sample FIFO

This block buffers 16-bit converter samples for a host that reads one byte per bus access. A completed sample enters through a single-cycle write strobe and occupies one word slot. The host drains the buffer as a byte stream: each sample comes out as its low byte and then its high byte. Two read strobes exist, one for each of the two host addresses a driver may use, and both have the same effect: they pop the next byte.

Status outputs give the empty, full, threshold and sticky overflow conditions. An interrupt flip-flop is set either when the fill level crosses a selectable threshold (buffer mode) or after every accepted sample (buffer disabled), and is cleared only by a dedicated clear strobe. A reset command empties the buffer and clears the overflow bit.

Top module: `sample_byte_fifo`

## Requirements
- R1: After rst_ni is released, empty_o is 1, and full_o, thr_o, ovf_o, irq_o and rd_data_o are all 0.
- R2: Bytes leave in arrival order; each sample yields bits [7:0] on the first pop and bits [15:8] on the second pop. rd_data_o shows the popped byte from the clock edge that samples the strobe until the next pop.
- R3: empty_o is 1 exactly when no byte is stored; a sample with only its low byte read keeps empty_o at 0. empty_o and full_o are never both 1.
- R4: A pop while empty_o is 1 drives rd_data_o to 0 and leaves the stored contents and order unchanged, including when a sample is written in the same cycle.
- R5: thr_o is 1 when the stored byte count is at least twice the selected threshold: 1024 samples (2048 bytes) when thr_sel_i is 0, 256 samples (512 bytes) when thr_sel_i is 1.
- R6: With fifo_en_i and irq_en_i both 1, irq_o rises one cycle after thr_o becomes 1 and stays 1 until a clear, even if the level falls below the threshold.
- R7: With fifo_en_i at 0 and irq_en_i at 1, irq_o becomes 1 at the edge that accepts a sample.
- R8: irq_clr_i forces irq_o to 0 at the next edge and wins over a set in the same cycle; with irq_en_i at 0 the flip-flop is never set.
- R9: full_o is 1 when fewer than two bytes are free (4095 or 4096 bytes stored). A sample arriving while full_o is 1 is dropped and sets ovf_o, which stays 1 until the reset command.
- R10: fifo_rst_i empties the buffer and clears ovf_o at the next edge, taking priority over a write or pop in the same cycle; it does not touch irq_o.
- R11: rd_lo_i and rd_hi_i each pop one byte; asserting both in one cycle pops a single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Sample write strobe |
| wr_data_i | input | 16 | Sample value |
| rd_lo_i | input | 1 | Pop strobe from the low-byte host address |
| rd_hi_i | input | 1 | Pop strobe from the high-byte host address |
| fifo_en_i | input | 1 | 1 selects threshold interrupts, 0 selects per-sample interrupts |
| thr_sel_i | input | 1 | 0: half-full threshold, 1: one-eighth threshold |
| fifo_rst_i | input | 1 | Reset command: empty buffer, clear overflow |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Interrupt flip-flop clear strobe |
| rd_data_o | output | 8 | Last popped byte |
| empty_o | output | 1 | No byte stored |
| full_o | output | 1 | Fewer than two bytes free |
| thr_o | output | 1 | Level at or above selected threshold |
| ovf_o | output | 1 | Sticky dropped-sample flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong byte-pointer bit shows as swapped low/high bytes on rd_data_o at the very next pop, while a count that drifts from the pointers shows as empty_o or full_o in the wrong cycle, so the bench checks the flags after every single operation. Threshold and full boundaries are probed one byte either side, where an off-by-one compare flips thr_o or full_o within one cycle. A lost or phantom write only surfaces when the stream is drained, so a complete fill past capacity is read back byte by byte against the expected pattern.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifo_cmd_t;

  function automatic fifo_cmd_t make_cmd(logic wr, logic rd_a, logic rd_b, logic clr);
    fifo_cmd_t c;
    c.push  = wr;
    c.pop   = rd_a | rd_b;
    c.clear = clr;
    return c;
  endfunction
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 2048,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic          rzero_i,
  input  logic [AW:0]   raddr_i,
  output logic [BW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_word;
  logic [BW-1:0] rd_byte;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rd_word = mem_q[raddr_i[AW:1]];
  assign rd_byte = raddr_i[0] ? rd_word[DW-1:BW] : rd_word[BW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rzero_i) rdata_o <= '0;
    else if (re_i)    rdata_o <= rd_byte;
  end

  AST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rzero_i |=> rdata_o == '0); // R4
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int DEPTH     = 2048,
  parameter int THR_HALF  = 1024,
  parameter int THR_EIGHT = 256,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clear_i,
  input  logic          thr_sel_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW:0]   rd_addr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          thr_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] BYTES    = CW'(2 * DEPTH);
  localparam logic [CW-1:0] LIM_HALF = CW'(2 * THR_HALF);
  localparam logic [CW-1:0] LIM_8TH  = CW'(2 * THR_EIGHT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] wp_q;
  logic [AW:0]   rp_q;
  logic          ovf_q;

  assign empty_o   = (cnt_q == '0);
  // a sample needs two free bytes; a half-read word still holds its slot
  assign full_o    = (cnt_q >= BYTES - CW'(1));
  assign thr_o     = (cnt_q >= (thr_sel_i ? LIM_8TH : LIM_HALF));
  assign push_ok_o = push_i & ~full_o & ~clear_i;
  assign pop_ok_o  = pop_i & ~empty_o & ~clear_i;
  assign wr_addr_o = wp_q;
  assign rd_addr_o = rp_q;
  assign ovf_o     = ovf_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok_o) cnt_d = cnt_d + CW'(2);
    if (pop_ok_o)  cnt_d = cnt_d - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (push_ok_o) wp_q <= wp_q + AW'(1);
      if (pop_ok_o)  rp_q <= rp_q + (AW+1)'(1);
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R3
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !push_i && !clear_i |=> empty_o); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !clear_i |=> full_o && ovf_o); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clear_i |=> ovf_o); // R9
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o && !ovf_o); // R10
endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_en_i,
  input  logic irq_en_i,
  input  logic clr_i,
  input  logic thr_i,
  input  logic sample_i,
  output logic irq_o
);
  logic set;

  assign set = irq_en_i & (fifo_en_i ? thr_i : sample_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (clr_i) irq_o <= 1'b0;
    else if (set)   irq_o <= 1'b1;
  end

  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o); // R8
  AST_IRQ_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i && !irq_o |=> !irq_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o); // R6
  AST_IRQ_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && irq_en_i && thr_i && !clr_i |=> irq_o); // R6
  AST_IRQ_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && irq_en_i && sample_i && !clr_i |=> irq_o); // R7
endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo #(
  parameter int SAMPLE_DEPTH = 2048,
  parameter int SAMPLE_W     = 16,
  parameter int THR_HALF     = SAMPLE_DEPTH / 2,
  parameter int THR_EIGHT    = SAMPLE_DEPTH / 8,
  localparam int AW          = $clog2(SAMPLE_DEPTH),
  localparam int BW          = SAMPLE_W / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  input  logic                rd_lo_i,
  input  logic                rd_hi_i,
  input  logic                fifo_en_i,
  input  logic                thr_sel_i,
  input  logic                fifo_rst_i,
  input  logic                irq_en_i,
  input  logic                irq_clr_i,
  output logic [BW-1:0]       rd_data_o,
  output logic                empty_o,
  output logic                full_o,
  output logic                thr_o,
  output logic                ovf_o,
  output logic                irq_o
);
  import sfifo_pkg::*;

  fifo_cmd_t     cmd;
  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_addr;
  logic [AW:0]   rd_addr;

  assign cmd = make_cmd(wr_valid_i, rd_lo_i, rd_hi_i, fifo_rst_i);

  sfifo_ctrl #(
    .DEPTH     (SAMPLE_DEPTH),
    .THR_HALF  (THR_HALF),
    .THR_EIGHT (THR_EIGHT)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (cmd.push),
    .pop_i     (cmd.pop),
    .clear_i   (cmd.clear),
    .thr_sel_i (thr_sel_i),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .thr_o     (thr_o),
    .ovf_o     (ovf_o)
  );

  sfifo_store #(
    .DEPTH (SAMPLE_DEPTH),
    .DW    (SAMPLE_W)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push_ok),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .re_i    (pop_ok),
    .rzero_i (cmd.pop & empty_o),
    .raddr_i (rd_addr),
    .rdata_o (rd_data_o)
  );

  sfifo_irq i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .irq_en_i  (irq_en_i),
    .clr_i     (irq_clr_i),
    .thr_i     (thr_o),
    .sample_i  (push_ok),
    .irq_o     (irq_o)
  );

  AST_ONE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i && rd_hi_i && !fifo_rst_i && !wr_valid_i && !empty_o && !full_o
    |=> !full_o); // R11
endmodule

// File: tb/test_sample_byte_fifo.sv
`timescale 1ns/1ps
module test_sample_byte_fifo;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_lo = 1'b0, rd_hi = 1'b0;
  logic        fifo_en = 1'b0, thr_sel = 1'b0, fifo_rst = 1'b0;
  logic        irq_en = 1'b0, irq_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        empty, full, thr, ovf, irq;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sample_byte_fifo i_sample_byte_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .fifo_en_i(fifo_en), .thr_sel_i(thr_sel),
    .fifo_rst_i(fifo_rst), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .rd_data_o(rd_data), .empty_o(empty), .full_o(full), .thr_o(thr),
    .ovf_o(ovf), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [15:0] d;
    logic        rl;
    logic        rh;
    logic        chk;
    logic [7:0]  exp_b;
    logic        exp_e;
  } vec_t;

  // one cycle per row; flags and data checked at the following falling edge
  localparam vec_t VECS [11] = '{
    '{4'd4,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1}, // R4 pop on empty
    '{4'd3,  1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R3
    '{4'd3,  1'b1, 16'hABCD, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R3
    '{4'd2,  1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'h34, 1'b0}, // R2 low first
    '{4'd2,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'h12, 1'b0}, // R2 then high
    '{4'd11, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hCD, 1'b0}, // R11 both strobes
    '{4'd11, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'hAB, 1'b1}, // R11 single pop above
    '{4'd4,  1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1}, // R4
    '{4'd4,  1'b1, 16'h00FF, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0}, // R4 pop+write on empty
    '{4'd4,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0}, // R4 order kept
    '{4'd3,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1}  // R3 empty again
  };

  function automatic logic [15:0] pat(int i);
    return 16'(i * 40503 + 7);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_valid = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0; fifo_rst = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic push(logic [15:0] d);
    wr_valid = 1'b1; wr_data = d;
    step();
  endtask

  task automatic pop();
    rd_lo = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 thr", thr, 0);
    chk("R1 ovf", ovf, 0); chk("R1 irq", irq, 0); chk("R1 data", rd_data, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 empty after release", empty, 1);

    for (int v = 0; v < 11; v++) begin
      wr_valid = VECS[v].wr; wr_data = VECS[v].d;
      rd_lo = VECS[v].rl; rd_hi = VECS[v].rh;
      step();
      chk($sformatf("R%0d vec%0d empty", VECS[v].req, v), empty, VECS[v].exp_e);
      if (VECS[v].chk)
        chk($sformatf("R%0d vec%0d data", VECS[v].req, v), rd_data, VECS[v].exp_b);
    end

    // R5/R6/R8: one-eighth threshold with interrupts
    thr_sel = 1'b1; fifo_en = 1'b1; irq_en = 1'b1;
    for (int i = 0; i < 255; i++) push(pat(i));
    chk("R5 below eighth", thr, 0);
    step();
    chk("R6 no irq below", irq, 0);
    push(pat(255));
    chk("R5 at eighth", thr, 1);
    chk("R6 irq not yet", irq, 0);
    step();
    chk("R6 irq one cycle after thr", irq, 1);
    pop();
    chk("R5 one byte below", thr, 0);
    step();
    chk("R6 irq sticky", irq, 1);
    irq_clr = 1'b1; step();
    chk("R8 clear", irq, 0);
    irq_en = 1'b0;
    push(pat(256));
    chk("R5 back above", thr, 1);
    step();
    chk("R8 disabled no set", irq, 0);
    irq_en = 1'b1; irq_clr = 1'b1; step();
    chk("R8 clear wins over set", irq, 0);
    step();
    chk("R6 set after clear released", irq, 1);

    // R10 reset command with concurrent write, irq untouched
    wr_valid = 1'b1; wr_data = 16'h5555; fifo_rst = 1'b1; step();
    chk("R10 empty", empty, 1); chk("R10 thr", thr, 0); chk("R10 irq kept", irq, 1);
    pop();
    chk("R10 nothing kept", rd_data, 0);
    irq_clr = 1'b1; irq_en = 1'b0; step();

    // R5/R9: half threshold, full and overflow
    thr_sel = 1'b0;
    for (int i = 0; i < 1023; i++) push(pat(i));
    chk("R5 below half", thr, 0);
    push(pat(1023));
    chk("R5 at half", thr, 1);
    for (int i = 1024; i < 2047; i++) push(pat(i));
    chk("R9 not full one slot left", full, 0);
    push(pat(2047));
    chk("R9 full", full, 1); chk("R9 no ovf yet", ovf, 0);
    push(16'hDEAD);
    chk("R9 ovf set", ovf, 1); chk("R9 still full", full, 1);
    pop();
    chk("R2 first byte", rd_data, {24'd0, pat(0)[7:0]});
    chk("R9 full with 4095 bytes", full, 1);
    push(16'hBEEF);
    begin
      int bad = 0;
      for (int k = 1; k < 4096; k++) begin
        logic [15:0] s;
        s = pat(k / 2);
        pop();
        if (rd_data !== ((k % 2) ? s[15:8] : s[7:0])) begin
          if (bad == 0)
            chk($sformatf("R2 byte %0d", k), rd_data, (k % 2) ? s[15:8] : s[7:0]);
          bad++;
        end
      end
      chk("R2 full readback mismatches", bad, 0);
    end
    chk("R3 empty after drain", empty, 1);
    chk("R9 ovf sticky", ovf, 1);
    fifo_rst = 1'b1; step();
    chk("R10 ovf cleared", ovf, 0);

    // R7: per-sample interrupts with buffer mode off
    fifo_en = 1'b0; irq_en = 1'b1;
    step();
    chk("R7 no sample no irq", irq, 0);
    push(16'h0102);
    chk("R7 irq on sample", irq, 1);
    irq_clr = 1'b1; step();
    chk("R7 cleared", irq, 0);
    push(16'h0304);
    chk("R7 irq on next sample", irq, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule